// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns a stream of bytes into asynchronous serial frames on one output line. A byte is offered on a valid/ready handshake. Once it is accepted, the line sends a low start bit, then the data bits least significant first, then an optional even parity bit, then one or two high stop bits. Between frames the line rests high.

The frame shape is chosen at runtime from setup inputs, not fixed at build time. A 2-bit length code selects 5 to 8 data bits, one select picks one or two stop bits, and another enables parity. A divider value sets the bit period in reference clock cycles. A transmitter enable gates the acceptance of new bytes, and a busy output shows that a frame is on the line. All setup inputs are captured at the moment a byte is accepted, so software may change them while a frame is in flight without corrupting it.

Top module: `uart_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, `tx_o` is 1 and `busy_o` is 0. `ready_o` equals `enable_i` while idle.
- R2: `ready_o` is 1 only when the block is idle and `enable_i` is 1. A byte is accepted on a clock edge where `valid_i` and `ready_o` are both 1. `busy_o` is 1 from the next cycle for exactly (total frame bits) x (`div_i`+1) cycles, and `ready_o` stays 0 for that whole time.
- R3: The first bit of a frame is a 0 start bit. The line changes only at bit boundaries, and every bit lasts `div_i`+1 clock cycles.
- R4: `len_code_i` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bit 0 of the byte is sent first, and byte bits at or above the selected length are not sent.
- R5: When `parity_en_i` is 1, one parity bit follows the last data bit. It makes the number of ones across the active data bits and the parity bit even. When `parity_en_i` is 0, no parity bit is sent.
- R6: `two_stop_i` = 0 gives one high stop bit and 1 gives two. The last cycle of every frame is high.
- R7: `div_i`, `len_code_i`, `two_stop_i`, `parity_en_i` and `data_i` are sampled only on the accepting edge. Changing them during a frame does not alter that frame.
- R8: With `enable_i` at 0 no byte is accepted. A frame already in progress completes in full, and the line then stays idle high.
- R9: `ready_o` returns to 1 in the first cycle after the last stop bit. A byte offered then has its start bit begin on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Transmitter enable |
| div_i | input | DIV_W | Bit period minus one, in clock cycles |
| len_code_i | input | 2 | Data length code (0..3 gives 5..8 bits) |
| two_stop_i | input | 1 | 0: one stop bit, 1: two stop bits |
| parity_en_i | input | 1 | Send an even parity bit |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on data_i is offered |
| ready_o | output | 1 | Block will accept a byte this cycle |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | A frame is on the line |

## Verification
Every combination of length code, parity enable and stop select is sent at divider values 0, 1 and 2. Every cycle of each frame is compared with a bit sequence worked out arithmetically, which separates errors in bit order, bit count, parity polarity and bit duration. All 256 byte values are then sent in the 8-bit parity frame, and all 32 values in the 5-bit frame, to find parity and masking faults that depend on the data. During each frame the setup inputs are scrambled to show that they are captured once per frame. A separate pass drops the enable in mid-frame and holds a byte on the input, to tell apart "finish and stop" from "abort" or "keep accepting".

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_BITS = 8;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  function automatic logic [CNT_W-1:0] code_to_bits(input logic [1:0] code);
    return CNT_W'(5) + CNT_W'(code);
  endfunction

  function automatic logic [MAX_BITS-1:0] bits_mask(input logic [CNT_W-1:0] nbits);
    return {MAX_BITS{1'b1}} >> (CNT_W'(MAX_BITS) - nbits);
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == div_i)  cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_end_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [1:0]          len_code_i,
  input  logic                parity_en_i,
  input  logic                two_stop_i,
  input  logic                bit_end_i,
  output logic                busy_o,
  output logic                tx_o
);
  tx_state_e           state_q;
  logic [MAX_BITS-1:0] shift_q;
  logic [CNT_W-1:0]    nbits_q;
  logic [CNT_W-1:0]    idx_q;
  logic                par_en_q, two_q, par_q, stop2_q;
  logic [CNT_W-1:0]    nbits_in;
  logic [MAX_BITS-1:0] masked;

  assign nbits_in = code_to_bits(len_code_i);
  assign masked   = data_i & bits_mask(nbits_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shift_q  <= '0;
      nbits_q  <= '0;
      idx_q    <= '0;
      par_en_q <= 1'b0;
      two_q    <= 1'b0;
      par_q    <= 1'b0;
      stop2_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_START;
          shift_q  <= masked;
          nbits_q  <= nbits_in;
          par_en_q <= parity_en_i;
          two_q    <= two_stop_i;
          par_q    <= ^masked;
        end
        ST_START: if (bit_end_i) begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: if (bit_end_i) begin
          shift_q <= shift_q >> 1;
          if (idx_q == nbits_q - 1'b1) begin
            state_q <= par_en_q ? ST_PARITY : ST_STOP;
            stop2_q <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PARITY: if (bit_end_i) begin
          state_q <= ST_STOP;
          stop2_q <= 1'b0;
        end
        ST_STOP: if (bit_end_i) begin
          if (two_q && !stop2_q) stop2_q <= 1'b1;
          else                   state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = shift_q[0];
      ST_PARITY: tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [1:0]          len_code_i,
  input  logic                two_stop_i,
  input  logic                parity_en_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic                tx_o,
  output logic                busy_o
);
  logic             accept, bit_end, busy;
  logic [DIV_W-1:0] div_q;

  assign ready_o = enable_i && !busy;
  assign accept  = valid_i && ready_o;
  assign busy_o  = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (accept) div_q <= div_i;
  end

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(accept),
    .run_i    (busy),
    .div_i    (div_q),
    .bit_end_o(bit_end)
  );

  uart_tx_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .data_i     (data_i),
    .len_code_i (len_code_i),
    .parity_en_i(parity_en_i),
    .two_stop_i (two_stop_i),
    .bit_end_i  (bit_end),
    .busy_o     (busy),
    .tx_o       (tx_o)
  );
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [DIV_W-1:0] div_i,
  input logic             valid_i,
  input logic             ready_o,
  input logic             tx_o,
  input logic             busy_o
);
  logic [DIV_W-1:0] div_snap, phase;
  logic             acc;

  assign acc = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_snap <= '0;
      phase    <= '0;
    end else if (acc) begin
      div_snap <= div_i;
      phase    <= '0;
    end else if (busy_o) begin
      phase <= (phase == div_snap) ? '0 : phase + 1'b1;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);  // R1
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && enable_i));  // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o);  // R2
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !tx_o);  // R3
  AST_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (tx_o != $past(tx_o))) |-> (phase == '0));  // R3
  AST_LAST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tx_o));  // R6
  AST_NO_ACCEPT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !ready_o);  // R8
endmodule

bind uart_frame_tx uart_tx_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .enable_i(enable_i),
  .div_i   (div_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .tx_o    (tx_o),
  .busy_o  (busy_o)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 16;
  localparam int WD_LIMIT   = 150000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic [1:0]       len_code_i = '0;
  logic             two_stop_i = 1'b0, parity_en_i = 1'b0, valid_i = 1'b0;
  logic [7:0]       data_i = '0;
  logic             ready_o, tx_o, busy_o;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx #(.DIV_W(DIV_W)) u_uart_frame_tx (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .div_i(div_i),
    .len_code_i(len_code_i), .two_stop_i(two_stop_i), .parity_en_i(parity_en_i),
    .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o), .tx_o(tx_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sends one byte, scrambles setup mid-frame (R7), checks every cycle of the frame
  task automatic run_frame(input logic [7:0] d, input int code, input int par,
                           input int two, input int dv, input bit drop_en);
    int exp_bits[12];
    string tag[12];
    int nb, total, ones;
    @(negedge clk);
    div_i = DIV_W'(dv); len_code_i = 2'(code); parity_en_i = par[0];
    two_stop_i = two[0]; data_i = d; valid_i = 1'b1;
    chk(ready_o == 1'b1, "R2", "ready before accept", int'(ready_o), 1);
    nb = code + 5;
    total = 1 + nb + par + 1 + two;
    ones = 0;
    exp_bits[0] = 0; tag[0] = "R3 start";
    for (int i = 0; i < nb; i++) begin
      exp_bits[1+i] = int'(d[i]); ones += int'(d[i]); tag[1+i] = "R4 data";
    end
    if (par != 0) begin exp_bits[1+nb] = ones % 2; tag[1+nb] = "R5 parity"; end
    for (int i = 1 + nb + par; i < total; i++) begin exp_bits[i] = 1; tag[i] = "R6 stop"; end
    @(negedge clk);
    valid_i = 1'b0;
    div_i = DIV_W'(dv + 3); len_code_i = ~2'(code); parity_en_i = ~par[0];
    two_stop_i = ~two[0]; data_i = ~d;
    if (drop_en) enable_i = 1'b0;
    for (int b = 0; b < total; b++) begin
      bit bad = 0;
      int act = 0;
      for (int c = 0; c <= dv; c++) begin
        if (b != 0 || c != 0) @(negedge clk);
        if (!bad && (tx_o !== exp_bits[b][0] || busy_o !== 1'b1 || ready_o !== 1'b0)) begin
          bad = 1; act = int'(tx_o);
        end
      end
      chk(!bad, tag[b], $sformatf("bit %0d len=%0d par=%0d two=%0d div=%0d d=%02h", b, nb, par, two, dv, d),
          bad ? act : exp_bits[b], exp_bits[b]);
    end
    @(negedge clk);
    // R9: idle and ready in the first cycle after the last stop bit; R7 frame length unchanged
    chk(busy_o == 1'b0 && tx_o == 1'b1 && ready_o == enable_i, "R9/R7",
        "end of frame busy", int'(busy_o), 0);
  endtask

  initial begin : watchdog
    repeat (WD_LIMIT) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_LIMIT, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    enable_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_o == 1'b1 && busy_o == 1'b0, "R1", "line during reset", int'(tx_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(tx_o == 1'b1 && busy_o == 1'b0, "R1", "line after reset", int'(tx_o), 1);
    chk(ready_o == 1'b1, "R1", "ready after reset, enabled", int'(ready_o), 1);
    enable_i = 1'b0;
    @(negedge clk);
    chk(ready_o == 1'b0, "R1", "ready after reset, disabled", int'(ready_o), 0);
    enable_i = 1'b1;

    // full format sweep
    for (int dv = 0; dv < 3; dv++)
      for (int code = 0; code < 4; code++)
        for (int par = 0; par < 2; par++)
          for (int two = 0; two < 2; two++)
            run_frame(8'(8'hA5 ^ (dv*29 + code*37 + par*11 + two*5)), code, par, two, dv, 1'b0);

    // data sweeps: 8-bit with parity, and 5-bit (upper bits masked, R4)
    for (int v = 0; v < 256; v++) run_frame(8'(v), 3, 1, 0, 0, 1'b0);
    for (int v = 0; v < 32; v++)  run_frame(8'(v) | 8'hE0, 0, 1, 1, 1, 1'b0);

    // R8: drop enable mid-frame; frame completes, nothing further accepted
    run_frame(8'h3C, 2, 1, 1, 2, 1'b1);
    begin
      bit bad = 0;
      @(negedge clk);
      valid_i = 1'b1; data_i = 8'h55;
      repeat (20) begin
        @(negedge clk);
        if (busy_o !== 1'b0 || tx_o !== 1'b1 || ready_o !== 1'b0) bad = 1;
      end
      chk(!bad, "R8", "idle while disabled with valid", int'(busy_o), 0);
      valid_i = 1'b0;
      enable_i = 1'b1;
    end
    run_frame(8'h96, 3, 0, 0, 4, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule